// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a two-ported shared memory. It watches the chip enable and address of a left and a right port. When both ports select the same location, it picks one winner and raises a busy flag toward the other side. While that flag is up, the losing side's write strobe is blocked inside the block, so its write never reaches the array. Reads are never blocked. The side that sees busy is expected to stall until the flag drops.

A mode pin selects master or slave behaviour, so several of these blocks can serve one wide word while only one decision is made. In master mode the block arbitrates and drives both busy pins. In slave mode it does not arbitrate. Each port's busy line then becomes an input that only blocks writes on that port, and the busy outputs sit at their inactive level.

Arbitration is registered. A collision presented before a clock edge shows up on busy after that edge, and releases the same way. The gated write enable is combinational and uses the registered busy. Address and chip enable must therefore be stable for one edge before the write strobe falls.

The block has no data path, so there is no valid/ready interface and no back-pressure. Every pin is a plain level.

Top module: `dual_port_busy_arb`

## Requirements
- R1: In master mode, a busy output (active low) goes low only at the clock edge after both ports were selected with equal addresses. Ports with different addresses, even differing in a single bit, never see busy.
- R2: A port whose chip enable is high (ce_n=1, active low) never takes part in a collision. In master mode, both busy outputs are high one edge after that.
- R3: If both ports start a matching access in the same cycle, the left port wins and the right busy goes low. The two busy outputs are never low together.
- R4: If one port already held the address in the previous cycle and the other arrives later, the port that was there first wins and the late side gets busy.
- R5: A winner keeps its grant for as long as it stays selected on the same address. If it deselects or changes address, the other side's busy returns high at the next clock edge, not before.
- R6: A write (rw=0 with we_n=0) from the side whose busy is low produces no write enable, and memory is left unchanged. A write from a side that is not busy is passed through.
- R7: Arbitration ignores rw. Two reads, or a read against a write, to the same address produce busy in the same way.
- R8: A selected read (ce_n=0, rw=1) always asserts that port's read enable, including while its busy is low.
- R9: With master_mode=0, both busy outputs stay high. Each port's busy_in_n input alone decides that port's writes: low blocks every write on the port, and high lets writes through.
- R10: After reset, there is no owner, both busy outputs are high, and no write enable is active while the ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = master (arbitrate), 0 = slave (busy lines are inhibit inputs) |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_rw | input | 1 | Left direction, 1 = read, 0 = write |
| l_we_n | input | 1 | Left write strobe, active low |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy in master mode, active low |
| l_wr_go | output | 1 | Left gated write enable toward the array |
| l_rd_go | output | 1 | Left read enable toward the array |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_rw | input | 1 | Right direction, 1 = read, 0 = write |
| r_we_n | input | 1 | Right write strobe, active low |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n | output | 1 | Right busy in master mode, active low |
| r_wr_go | output | 1 | Right gated write enable toward the array |
| r_rd_go | output | 1 | Right read enable toward the array |

## Verification
The bench builds the block with ADDR_W=4. With that width, a 16-entry memory model fits in the bench, and every write can be checked against the whole array. It also keeps near-miss addresses, such as ones differing only in the top bit, easy to aim at. The bench runs the default clocking and both modes. The scenarios cover:
- same-cycle arrival,
- late arrival,
- grant hold and release,
- a busy-side read,
- slave-side inhibit.

The timing of arbitration does not depend on the address width.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;

  localparam int NPORT  = 2;
  localparam int P_LEFT = 0;
  localparam int P_RGT  = 1;
endpackage

// File: rtl/dpb_port_track.sv
module dpb_port_track #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic              stayed
);
  logic              prev_sel;
  logic [ADDR_W-1:0] prev_addr;

  assign sel    = !ce_n;
  // selected now and already selected on this address one cycle ago
  assign stayed = sel && prev_sel && (prev_addr == addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel  <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_sel  <= sel;
      prev_addr <= addr;
    end
  end
endmodule

// File: rtl/dpb_arbiter.sv
module dpb_arbiter
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_l,
  input  logic              sel_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              stay_l,
  input  logic              stay_r,
  output logic              busy_l,
  output logic              busy_r
);
  owner_e owner_q;
  owner_e winner;
  logic   match;

  assign match = sel_l && sel_r && (addr_l == addr_r);

  always_comb begin
    winner = OWN_NONE;
    if (match) begin
      if (owner_q == OWN_LEFT && stay_l)       winner = OWN_LEFT;
      else if (owner_q == OWN_RIGHT && stay_r) winner = OWN_RIGHT;
      else if (stay_r && !stay_l)              winner = OWN_RIGHT;
      else                                     winner = OWN_LEFT;  // earlier left or tie
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      busy_l  <= 1'b0;
      busy_r  <= 1'b0;
    end else begin
      owner_q <= winner;
      busy_l  <= (winner == OWN_RIGHT);
      busy_r  <= (winner == OWN_LEFT);
    end
  end
endmodule

// File: rtl/dpb_port_gate.sv
module dpb_port_gate (
  input  logic master,
  input  logic ce_n,
  input  logic rw,
  input  logic we_n,
  input  logic busy_int,
  input  logic busy_in_n,
  output logic busy_out_n,
  output logic wr_go,
  output logic rd_go
);
  logic inhibit;

  assign inhibit    = master ? busy_int : !busy_in_n;
  assign busy_out_n = master ? !busy_int : 1'b1;
  assign wr_go      = !ce_n && !rw && !we_n && !inhibit;
  assign rd_go      = !ce_n && rw;
endmodule

// File: rtl/dual_port_busy_arb.sv
module dual_port_busy_arb
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_rw,
  input  logic              l_we_n,
  input  logic              l_busy_in_n,
  output logic              l_busy_n,
  output logic              l_wr_go,
  output logic              l_rd_go,
  input  logic              r_ce_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_rw,
  input  logic              r_we_n,
  input  logic              r_busy_in_n,
  output logic              r_busy_n,
  output logic              r_wr_go,
  output logic              r_rd_go
);
  logic [ADDR_W-1:0] addr_a [NPORT];
  logic [NPORT-1:0]  ce_n_a, rw_a, we_n_a, bin_a, bout_a, wr_a, rd_a;
  logic [NPORT-1:0]  sel_a, stay_a, busy_a;

  assign addr_a[P_LEFT] = l_addr;
  assign addr_a[P_RGT]  = r_addr;
  assign ce_n_a = {r_ce_n, l_ce_n};
  assign rw_a   = {r_rw, l_rw};
  assign we_n_a = {r_we_n, l_we_n};
  assign bin_a  = {r_busy_in_n, l_busy_in_n};

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    dpb_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n_a[i]),
      .addr   (addr_a[i]),
      .sel    (sel_a[i]),
      .stayed (stay_a[i])
    );
    dpb_port_gate u_gate (
      .master     (master_mode),
      .ce_n       (ce_n_a[i]),
      .rw         (rw_a[i]),
      .we_n       (we_n_a[i]),
      .busy_int   (busy_a[i]),
      .busy_in_n  (bin_a[i]),
      .busy_out_n (bout_a[i]),
      .wr_go      (wr_a[i]),
      .rd_go      (rd_a[i])
    );
  end

  dpb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_l  (sel_a[P_LEFT]),
    .sel_r  (sel_a[P_RGT]),
    .addr_l (addr_a[P_LEFT]),
    .addr_r (addr_a[P_RGT]),
    .stay_l (stay_a[P_LEFT]),
    .stay_r (stay_a[P_RGT]),
    .busy_l (busy_a[P_LEFT]),
    .busy_r (busy_a[P_RGT])
  );

  assign l_busy_n = bout_a[P_LEFT];
  assign r_busy_n = bout_a[P_RGT];
  assign l_wr_go  = wr_a[P_LEFT];
  assign r_wr_go  = wr_a[P_RGT];
  assign l_rd_go  = rd_a[P_LEFT];
  assign r_rd_go  = rd_a[P_RGT];
endmodule

// File: rtl/dpb_checker.sv
module dpb_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_ce_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_rw,
  input logic              l_busy_in_n,
  input logic              l_busy_n,
  input logic              l_wr_go,
  input logic              l_rd_go,
  input logic              r_ce_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_rw,
  input logic              r_busy_in_n,
  input logic              r_busy_n,
  input logic              r_wr_go,
  input logic              r_rd_go
);
  AST_ONE_SIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R3
  AST_ADDR_DIFF_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && $past(l_addr != r_addr)) |-> (l_busy_n && r_busy_n)); // R1
  AST_CE_OFF_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && $past(l_ce_n || r_ce_n)) |-> (l_busy_n && r_busy_n)); // R2
  AST_LEFT_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !l_busy_n) |-> !l_wr_go); // R6
  AST_RIGHT_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !r_busy_n) |-> !r_wr_go); // R6
  AST_LEFT_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && l_rw) |-> l_rd_go); // R8
  AST_RIGHT_READ_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && r_rw) |-> r_rd_go); // R8
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n)); // R9
  AST_SLAVE_LEFT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !l_busy_in_n) |-> !l_wr_go); // R9
  AST_SLAVE_RIGHT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !r_busy_in_n) |-> !r_wr_go); // R9
endmodule

bind dual_port_busy_arb dpb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .master_mode (master_mode),
  .l_ce_n      (l_ce_n),
  .l_addr      (l_addr),
  .l_rw        (l_rw),
  .l_busy_in_n (l_busy_in_n),
  .l_busy_n    (l_busy_n),
  .l_wr_go     (l_wr_go),
  .l_rd_go     (l_rd_go),
  .r_ce_n      (r_ce_n),
  .r_addr      (r_addr),
  .r_rw        (r_rw),
  .r_busy_in_n (r_busy_in_n),
  .r_busy_n    (r_busy_n),
  .r_wr_go     (r_wr_go),
  .r_rd_go     (r_rd_go)
);

// File: tb/sim_dual_port_busy_arb.sv
`timescale 1ns/1ps
module sim_dual_port_busy_arb;
  localparam int CLK_NS = 10;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_ce_n = 1'b1, l_rw = 1'b1, l_we_n = 1'b1, l_busy_in_n = 1'b1;
  logic r_ce_n = 1'b1, r_rw = 1'b1, r_we_n = 1'b1, r_busy_in_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_din = '0, r_din = '0;
  logic l_busy_n, l_wr_go, l_rd_go, r_busy_n, r_wr_go, r_rd_go;
  logic [7:0] mem [DEPTH];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dual_port_busy_arb #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce_n(l_ce_n), .l_addr(l_addr), .l_rw(l_rw), .l_we_n(l_we_n),
    .l_busy_in_n(l_busy_in_n), .l_busy_n(l_busy_n), .l_wr_go(l_wr_go), .l_rd_go(l_rd_go),
    .r_ce_n(r_ce_n), .r_addr(r_addr), .r_rw(r_rw), .r_we_n(r_we_n),
    .r_busy_in_n(r_busy_in_n), .r_busy_n(r_busy_n), .r_wr_go(r_wr_go), .r_rd_go(r_rd_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // let inputs settle, commit gated writes to the model, advance one clock
  task automatic cyc();
    #1;
    if (l_wr_go) mem[l_addr] = l_din;
    if (r_wr_go) mem[r_addr] = r_din;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    l_ce_n = 1; l_rw = 1; l_we_n = 1;
    r_ce_n = 1; r_rw = 1; r_we_n = 1;
    cyc();
  endtask

  task automatic t_reset();
    #1;
    chk(l_busy_n && r_busy_n, "R10 busy after reset", {l_busy_n, r_busy_n}, 3);
    chk(!l_wr_go && !r_wr_go, "R10 no write when idle", {l_wr_go, r_wr_go}, 0);
  endtask

  task automatic t_distinct();
    l_ce_n = 0; l_addr = 3; l_rw = 0; l_we_n = 0; l_din = 8'hA5;
    r_ce_n = 0; r_addr = 4; r_rw = 0; r_we_n = 0; r_din = 8'h3C;
    cyc();
    chk(l_busy_n && r_busy_n, "R1 distinct addresses", {l_busy_n, r_busy_n}, 3);
    chk(mem[3] == 8'hA5 && mem[4] == 8'h3C, "R6 free writes land", {mem[3], mem[4]}, 16'hA53C);
    idle();
    l_ce_n = 0; l_addr = 4'b1000; r_ce_n = 0; r_addr = 4'b0000;
    cyc();
    chk(l_busy_n && r_busy_n, "R1 near-miss MSB", {l_busy_n, r_busy_n}, 3);
    idle();
  endtask

  task automatic t_ce_off();
    l_ce_n = 1; l_addr = 5; r_ce_n = 0; r_addr = 5;
    cyc(); cyc();
    chk(l_busy_n && r_busy_n, "R2 deselected port", {l_busy_n, r_busy_n}, 3);
    idle();
  endtask

  task automatic t_tie();
    l_ce_n = 0; l_addr = 6; r_ce_n = 0; r_addr = 6;
    #1;
    chk(l_busy_n && r_busy_n, "R1 busy waits for edge", {l_busy_n, r_busy_n}, 3);
    cyc();
    chk(l_busy_n && !r_busy_n, "R3 tie goes left", {l_busy_n, r_busy_n}, 2);
    l_rw = 0; l_we_n = 0; l_din = 8'h11;
    r_rw = 0; r_we_n = 0; r_din = 8'h77;
    #1;
    chk(!r_wr_go, "R6 busy right write gated", r_wr_go, 0);
    chk(l_wr_go, "R6 owner write passes", l_wr_go, 1);
    cyc();
    chk(mem[6] == 8'h11, "R6 memory keeps owner data", mem[6], 8'h11);
    l_rw = 1; l_we_n = 1; r_rw = 1; r_we_n = 1;
    #1;
    chk(r_rd_go && !r_busy_n, "R8 busy side still reads", {r_rd_go, r_busy_n}, 2);
    chk(mem[r_addr] == 8'h11, "R8 read data", mem[r_addr], 8'h11);
    idle();
    chk(l_busy_n && r_busy_n, "R5 release after idle", {l_busy_n, r_busy_n}, 3);
  endtask

  task automatic t_rw_ignored();
    l_ce_n = 0; l_addr = 2; l_rw = 1;
    r_ce_n = 0; r_addr = 2; r_rw = 0; r_we_n = 1;
    cyc();
    chk(l_busy_n && !r_busy_n, "R7 read vs write collides", {l_busy_n, r_busy_n}, 2);
    idle();
  endtask

  task automatic t_first();
    r_ce_n = 0; r_addr = 9;
    cyc();
    l_ce_n = 0; l_addr = 9;
    cyc();
    chk(!l_busy_n && r_busy_n, "R4 earlier right keeps", {l_busy_n, r_busy_n}, 1);
    l_rw = 0; l_we_n = 0; l_din = 8'hEE;
    #1;
    chk(!l_wr_go, "R6 late left write gated", l_wr_go, 0);
    cyc();
    chk(mem[9] == 8'd27, "R6 memory untouched", mem[9], 27);
    l_rw = 1; l_we_n = 1;
    r_addr = 10;
    #1;
    chk(!l_busy_n, "R5 busy held until edge", l_busy_n, 0);
    cyc();
    chk(l_busy_n && r_busy_n, "R5 release on address move", {l_busy_n, r_busy_n}, 3);
    r_addr = 9;
    cyc();
    chk(l_busy_n && !r_busy_n, "R4 left now earlier", {l_busy_n, r_busy_n}, 2);
    idle();
  endtask

  task automatic t_hold();
    l_ce_n = 0; l_addr = 12; r_ce_n = 0; r_addr = 12;
    cyc();
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk(l_busy_n && !r_busy_n, "R5 grant held", {l_busy_n, r_busy_n}, 2);
    end
    l_ce_n = 1;
    #1;
    chk(!r_busy_n, "R5 no early release", r_busy_n, 0);
    cyc();
    chk(r_busy_n && l_busy_n, "R5 release after deselect", {l_busy_n, r_busy_n}, 3);
    idle();
  endtask

  task automatic t_slave();
    master_mode = 0;
    l_ce_n = 0; l_addr = 13; l_rw = 0; l_we_n = 0; l_din = 8'h5A;
    r_ce_n = 0; r_addr = 13; r_rw = 1;
    cyc();
    r_addr = 14; r_rw = 0; r_we_n = 0; r_din = 8'hC3;
    #1;
    chk(l_busy_n && r_busy_n, "R9 slave busy outs high", {l_busy_n, r_busy_n}, 3);
    chk(l_wr_go && r_wr_go, "R9 slave writes pass", {l_wr_go, r_wr_go}, 3);
    cyc();
    chk(mem[13] == 8'h5A && mem[14] == 8'hC3, "R9 slave writes land", {mem[13], mem[14]}, 16'h5AC3);
    l_busy_in_n = 0; l_din = 8'h00; r_din = 8'h99;
    #1;
    chk(!l_wr_go && r_wr_go, "R9 inhibit left only", {l_wr_go, r_wr_go}, 1);
    cyc();
    chk(mem[13] == 8'h5A, "R9 inhibited write absent", mem[13], 8'h5A);
    l_busy_in_n = 1;
    idle();
    master_mode = 1;
    idle();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_distinct();
    t_ce_off();
    t_tie();
    t_rw_ignored();
    t_first();
    t_hold();
    t_slave();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 5000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule